// File: doc/BRIEF.md
# ISA Memory Cycle Forwarding Decoder

This block looks at every memory cycle that an ISA master or the DMA controller starts and makes two decisions without waiting for a clock. The first is whether the cycle is claimed and passed on to PCI. The second is whether the BIOS chip select is asserted. The address bits that matter are the 64 KB block number, which is address bits 23:16 taken from the latched and system address lines. Both outputs are combinational functions of that block number, the refresh and DMA indicators, and a small set of configuration registers.

The forwarded region starts at 1 MB and ends at a programmable top block. A programmable hole inside that region can exempt a run of 64 KB blocks from forwarding. The BIOS window is the 128 KB below 1 MB. Its upper 64 KB always selects the BIOS device. Its lower 64 KB selects the BIOS device only when enabled. A BIOS hit is never also forwarded. The configuration registers are written through a simple clocked write port, and a write is seen by cycles decoded after the writing clock edge.

Top module: `isa_mem_fwd_dec`

## Requirements
- R1: After reset the top block is 0xFF (16 MB), the hole is disabled and the lower BIOS half is disabled.
- R2: A block from 0x10 up to and including the top block (register 0) asserts `fwd_pci`. A block above the top block does not.
- R3: A block below 0x10 (under 1 MB) never asserts `fwd_pci`.
- R4: With the hole enabled (register 3 bit 0), blocks from the hole base (register 1) through base+size-1 (size in register 2) do not assert `fwd_pci`. The blocks just outside the hole are forwarded normally, and a hole part beyond the top has no added effect.
- R5: A hole whose size is zero, or whose enable bit is clear, has no effect on forwarding.
- R6: A size value above 128 acts as 128 blocks (8 MB).
- R7: Block 0x0F (0x0F0000 to 0x0FFFFF) always drives `bios_cs_n` low unless it is suppressed by R9.
- R8: Block 0x0E drives `bios_cs_n` low only when register 3 bit 1 is set. Every other block leaves `bios_cs_n` high.
- R9: `bios_cs_n` stays high while `isa_refresh` or `isa_dma` is high. These two inputs do not change `fwd_pci`.
- R10: `bios_cs_n` low and `fwd_pci` high never occur together, and both outputs follow the address within the same cycle.
- R11: A register is updated only at a clock edge where `cfg_we` is high, and the new value is used by cycles decoded after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register select: 0 top block, 1 hole base, 2 hole size, 3 control |
| cfg_wdata | input | 8 | Write data. For the control register, bit 0 enables the hole and bit 1 enables the lower BIOS half |
| isa_blk | input | 8 | Address bits 23:16 of the current ISA memory cycle |
| isa_refresh | input | 1 | High during a refresh cycle |
| isa_dma | input | 1 | High during a DMA cycle |
| fwd_pci | output | 1 | High when the cycle is to be forwarded to PCI |
| bios_cs_n | output | 1 | Active-low BIOS chip select |

## Verification
The properties sample the combinational outputs at clock edges. They therefore assume that the block number and the refresh and DMA indicators are steady across each edge. The bench meets this by changing those inputs only on the falling edge. The register stability property assumes that `cfg_we` is low unless the bench means to write. The write task raises it for exactly one rising edge and then lowers it again.

// File: rtl/isa_fwd_pkg.sv
package isa_fwd_pkg;
  localparam int BLK_W     = 8;
  localparam int SZ_W      = BLK_W + 1;
  localparam int HOLE_MAX  = 128;
  localparam logic [BLK_W-1:0] LOW_LIMIT = 8'h10;
  localparam logic [BLK_W-1:0] BIOS_LO   = 8'h0E;
  localparam logic [BLK_W-1:0] BIOS_HI   = 8'h0F;

  typedef struct packed {
    logic [BLK_W-1:0] top_blk;
    logic [BLK_W-1:0] hole_base;
    logic [BLK_W-1:0] hole_size;
    logic             hole_en;
    logic             low_bios_en;
  } cfg_t;

  function automatic logic [SZ_W-1:0] eff_size(input logic [BLK_W-1:0] sz);
    logic [SZ_W-1:0] wide;
    wide = {1'b0, sz};
    return (wide > SZ_W'(HOLE_MAX)) ? SZ_W'(HOLE_MAX) : wide;
  endfunction

  function automatic logic hole_hit(input logic [BLK_W-1:0] blk,
                                    input logic [BLK_W-1:0] base,
                                    input logic [BLK_W-1:0] sz);
    logic [SZ_W-1:0] lim;
    lim = {1'b0, base} + eff_size(sz);
    return ({1'b0, blk} >= {1'b0, base}) && ({1'b0, blk} < lim);
  endfunction

  function automatic logic in_region(input logic [BLK_W-1:0] blk,
                                     input logic [BLK_W-1:0] top);
    return (blk >= LOW_LIMIT) && (blk <= top);
  endfunction
endpackage

// File: rtl/isa_fwd_cfg.sv
module isa_fwd_cfg
  import isa_fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [BLK_W-1:0] wdata,
  output cfg_t             cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.top_blk     <= '1;
      cfg_q.hole_base   <= '0;
      cfg_q.hole_size   <= '0;
      cfg_q.hole_en     <= 1'b0;
      cfg_q.low_bios_en <= 1'b0;
    end else if (we) begin
      case (addr)
        2'd0: cfg_q.top_blk   <= wdata;
        2'd1: cfg_q.hole_base <= wdata;
        2'd2: cfg_q.hole_size <= wdata;
        default: begin
          cfg_q.hole_en     <= wdata[0];
          cfg_q.low_bios_en <= wdata[1];
        end
      endcase
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/isa_fwd_region.sv
module isa_fwd_region
  import isa_fwd_pkg::*;
(
  input  logic [BLK_W-1:0] blk,
  input  cfg_t             cfg,
  output logic             hole_hit_o,
  output logic             fwd
);
  logic region_hit;

  always_comb begin
    region_hit = in_region(blk, cfg.top_blk);
    hole_hit_o = cfg.hole_en && (cfg.hole_size != '0) &&
                 hole_hit(blk, cfg.hole_base, cfg.hole_size);
    fwd        = region_hit && !hole_hit_o;
  end
endmodule

// File: rtl/isa_fwd_bios.sv
module isa_fwd_bios
  import isa_fwd_pkg::*;
(
  input  logic [BLK_W-1:0] blk,
  input  logic             low_en,
  input  logic             refresh,
  input  logic             dma,
  output logic             bios_hit,
  output logic             cs_n
);
  always_comb begin
    bios_hit = (blk == BIOS_HI) || ((blk == BIOS_LO) && low_en);
    cs_n     = !(bios_hit && !refresh && !dma);
  end
endmodule

// File: rtl/isa_mem_fwd_dec.sv
module isa_mem_fwd_dec
  import isa_fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [BLK_W-1:0] cfg_wdata,
  input  logic [BLK_W-1:0] isa_blk,
  input  logic             isa_refresh,
  input  logic             isa_dma,
  output logic             fwd_pci,
  output logic             bios_cs_n
);
  cfg_t cfg;
  logic hole_hit_w;
  logic bios_hit_w;
  logic region_fwd_w;
  logic [BLK_W-1:0] top_blk_q;

  isa_fwd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  isa_fwd_region u_region (
    .blk(isa_blk), .cfg(cfg), .hole_hit_o(hole_hit_w), .fwd(region_fwd_w)
  );

  isa_fwd_bios u_bios (
    .blk(isa_blk), .low_en(cfg.low_bios_en), .refresh(isa_refresh),
    .dma(isa_dma), .bios_hit(bios_hit_w), .cs_n(bios_cs_n)
  );

  assign top_blk_q = cfg.top_blk;
  // A BIOS hit is kept off PCI even if the region were to overlap it.
  assign fwd_pci   = region_fwd_w && !bios_hit_w;
endmodule

// File: rtl/isa_mem_fwd_dec_chk.sv
module isa_mem_fwd_dec_chk
  import isa_fwd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [BLK_W-1:0] isa_blk,
  input logic             isa_refresh,
  input logic             isa_dma,
  input logic             fwd_pci,
  input logic             bios_cs_n,
  input logic [BLK_W-1:0] top_blk_q,
  input logic             hole_hit_w
);
  a_r10_cs_excludes_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    !bios_cs_n |-> !fwd_pci);
  a_r9_cs_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_refresh || isa_dma) |-> bios_cs_n);
  a_r3_low_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_blk < LOW_LIMIT) |-> !fwd_pci);
  a_r7_upper_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_blk == BIOS_HI && !isa_refresh && !isa_dma) |-> !bios_cs_n);
  a_r8_other_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_blk != BIOS_HI && isa_blk != BIOS_LO) |-> bios_cs_n);
  a_r4_hole_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    hole_hit_w |-> !fwd_pci);
  a_r2_above_top: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_blk > top_blk_q) |-> !fwd_pci);
  a_r11_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(top_blk_q));
endmodule

bind isa_mem_fwd_dec isa_mem_fwd_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .isa_blk(isa_blk),
  .isa_refresh(isa_refresh), .isa_dma(isa_dma), .fwd_pci(fwd_pci),
  .bios_cs_n(bios_cs_n), .top_blk_q(top_blk_q), .hole_hit_w(hole_hit_w)
);

// File: tb/isa_mem_fwd_dec_tb.sv
module isa_mem_fwd_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {req[3:0], blk[7:0], refresh, dma, exp_fwd, exp_cs_n}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd7,  8'h0F, 1'b0, 1'b0, 1'b0, 1'b0},  // R7 upper BIOS
    {4'd8,  8'h0E, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 lower BIOS enabled
    {4'd9,  8'h0E, 1'b1, 1'b0, 1'b0, 1'b1},  // R9 refresh blocks
    {4'd9,  8'h0F, 1'b0, 1'b1, 1'b0, 1'b1},  // R9 dma blocks
    {4'd3,  8'h0D, 1'b0, 1'b0, 1'b0, 1'b1},  // R3
    {4'd3,  8'h00, 1'b0, 1'b0, 1'b0, 1'b1},  // R3
    {4'd2,  8'h10, 1'b0, 1'b0, 1'b1, 1'b1},  // R2 bottom
    {4'd2,  8'h7F, 1'b0, 1'b0, 1'b1, 1'b1},  // R2 top
    {4'd2,  8'h80, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 above top
    {4'd4,  8'h1F, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 below hole
    {4'd4,  8'h20, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 hole start
    {4'd4,  8'h2F, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 hole end
    {4'd4,  8'h30, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 after hole
    {4'd9,  8'h10, 1'b1, 1'b1, 1'b1, 1'b1}   // R9 fwd unaffected
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, isa_blk = '0;
  logic isa_refresh = 1'b0, isa_dma = 1'b0, fwd_pci, bios_cs_n;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_mem_fwd_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .isa_blk(isa_blk), .isa_refresh(isa_refresh),
    .isa_dma(isa_dma), .fwd_pci(fwd_pci), .bios_cs_n(bios_cs_n)
  );

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] b, input logic r,
                     input logic d, input logic ef, input logic ec);
    @(negedge clk); isa_blk = b; isa_refresh = r; isa_dma = d;
    #1;
    n_run++;
    if (fwd_pci !== ef || bios_cs_n !== ec) begin
      n_fail++;
      $display("FAIL %s blk=%h: fwd=%b cs_n=%b expected fwd=%b cs_n=%b",
               req, b, fwd_pci, bios_cs_n, ef, ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", 8'hFF, 0, 0, 1, 1);
    chk("R1", 8'h0E, 0, 0, 0, 1);
    chk("R1", 8'h0F, 0, 0, 0, 0);
    chk("R1", 8'h20, 0, 0, 1, 1);
    // table configuration: top 0x7F, hole 0x20..0x2F, lower BIOS on
    wr(2'd0, 8'h7F); wr(2'd1, 8'h20); wr(2'd2, 8'h10); wr(2'd3, 8'h03);
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      chk($sformatf("R%0d", v[15:12]), v[11:4], v[3], v[2], v[1], v[0]);
    end
    // R8 lower half disabled again
    wr(2'd3, 8'h01);
    chk("R8", 8'h0E, 0, 0, 0, 1);
    // R5 zero size with enable set
    wr(2'd2, 8'h00);
    chk("R5", 8'h20, 0, 0, 1, 1);
    // R5 enable clear with nonzero size
    wr(2'd2, 8'h10); wr(2'd3, 8'h00);
    chk("R5", 8'h20, 0, 0, 1, 1);
    // R6 oversize hole clamps to 128 blocks: 0x10..0x8F
    wr(2'd0, 8'hFF); wr(2'd1, 8'h10); wr(2'd2, 8'hFF); wr(2'd3, 8'h01);
    chk("R6", 8'h8F, 0, 0, 0, 1);
    chk("R6", 8'h90, 0, 0, 1, 1);
    // R4 hole past top: top 0x3F, hole 0x30..0x6F
    wr(2'd0, 8'h3F); wr(2'd1, 8'h30); wr(2'd2, 8'h40);
    chk("R4", 8'h2F, 0, 0, 1, 1);
    chk("R4", 8'h30, 0, 0, 0, 1);
    chk("R4", 8'h40, 0, 0, 0, 1);
    // R11 write without enable is ignored, then a real write takes effect
    @(negedge clk); cfg_addr = 2'd0; cfg_wdata = 8'hFF; cfg_we = 1'b0;
    @(negedge clk);
    chk("R11", 8'h40, 0, 0, 0, 1);
    wr(2'd0, 8'hFF);
    chk("R11", 8'h70, 0, 0, 1, 1);
    // R10 BIOS hit not forwarded even with region covering everything
    chk("R10", 8'h0F, 0, 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule